// File: doc/BRIEF.md
# ISA Slave I/O Front End

This block is the slave side of a peripheral on an 8-bit ISA I/O bus. It compares each bus address with a programmable base address. It qualifies the match with the active-low address enable and with a chip-enable input. From the bus read and write strobes it produces single-cycle strobes in the internal clock domain for the peripheral's registers. While the peripheral itself is the target of a bus cycle, it drives an active-low enable to an external data transceiver.

The block holds a two-bit general-purpose output register in the window at offset 7. It also routes one internal interrupt request and one DMA request onto pad groups. Software picks the pin in each group, and every other pin in the group is left undriven. The block only produces pad controls (value, output enable, weak pull-down enable), so the pad ring builds the tristate. The base address and both routing selections are inputs from elsewhere in the chip. The block also passes an inverted copy of the active-high bus reset to an output.

Top module: `isa_io_front`

## Requirements
- R1: An address matches only when bits 11 and 10 are both 0 and bits 9:4 equal `base_hi`. Bits 3:0 give the register offset inside the 16-byte window.
- R2: No decode happens while `aen_n` is high.
- R3: While `chip_en` is low, no read or write is decoded, `data_oe` stays 0, and every `irq_oe`, `drq_oe` and `drq_pd` bit is 0.
- R4: `xcvr_en_n` is 0 exactly while a decoded address is present and `ior_n` or `iow_n` is low. Otherwise it is 1.
- R5: A decoded write gives exactly one `wr_stb` pulse of one cycle after the synchronised rising edge of `iow_n`. `wr_off` and `wr_data` carry the offset and data sampled while the strobe was low. An undecoded write gives no pulse.
- R6: `data_oe` is 1 only while a decoded address is present and `ior_n` is low. Each decoded read gives exactly one `rd_stb` pulse.
- R7: During a read, offset 7 returns 6'b0 in bits 7:2 and `gpo` in bits 1:0. Any other offset returns `rd_data`.
- R8: Reset sets `gpo` to 2'b10 (bit 0 low, bit 1 high). A write to offset 7 loads `gpo` from data bits 1:0. No other write changes it.
- R9: `bus_rst_n_o` is always the inverse of `bus_rst`.
- R10: With `chip_en` high and `irq_sel` below 5, only pin `irq_sel` has `irq_oe` set, and it carries `irq_req`. A selection of 5 to 7 drives no pin.
- R11: With `chip_en` high and `drq_sel` below 3, the selected pin alone is involved. It is driven high (`drq_oe`=1, `drq_o`=1) while `drq_req` is 1. Otherwise it is undriven with only its `drq_pd` bit set. A selection of 3 drives no pin and enables no pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Active-high bus reset |
| bus_rst_n_o | output | 1 | Inverted bus reset |
| chip_en | input | 1 | Active-high chip enable gating the whole interface |
| aen_n | input | 1 | Active-low address enable |
| addr | input | 12 | Bus address |
| ior_n | input | 1 | Active-low bus read strobe |
| iow_n | input | 1 | Active-low bus write strobe |
| base_hi | input | 6 | Programmed base address bits 9:4 |
| data_i | input | 8 | Bus write data |
| data_o | output | 8 | Bus read data |
| data_oe | output | 1 | Data bus output enable |
| xcvr_en_n | output | 1 | Active-low external transceiver enable |
| wr_stb | output | 1 | Single-cycle internal write strobe |
| wr_off | output | 4 | Offset of the write |
| wr_data | output | 8 | Data of the write |
| rd_stb | output | 1 | Single-cycle internal read strobe |
| rd_off | output | 4 | Offset currently addressed for read |
| rd_data | input | 8 | Read data from internal registers |
| gpo | output | 2 | General-purpose outputs |
| irq_sel | input | 3 | Interrupt pin selection |
| irq_req | input | 1 | Internal interrupt request |
| irq_o | output | 5 | Interrupt pad values |
| irq_oe | output | 5 | Interrupt pad output enables |
| drq_sel | input | 2 | DMA request pin selection |
| drq_req | input | 1 | Internal DMA request |
| drq_o | output | 3 | DMA request pad values |
| drq_oe | output | 3 | DMA request pad output enables |
| drq_pd | output | 3 | DMA request pad weak pull-down enables |

## Verification
The assertions assume a few things about the bus. Address, data and enables stay steady while a strobe is low and for a few clock cycles after it rises. Each strobe stays low for several internal clock periods. The bench's bus tasks keep to this: they set up the address one cycle before lowering a strobe, hold it low for four cycles, and wait five cycles after release before changing the address. All bus inputs change on the falling clock edge, away from the synchroniser's sampling edge.

// File: rtl/isa_io_pkg.sv
// Shared constants for the ISA slave front end.
// Assumes a 12-bit I/O address space of which 10 bits are compared.
package isa_io_pkg;
    localparam int ADDR_W = 12;   // bus address width
    localparam int DEC_W  = 10;   // bits compared against the base
    localparam int DATA_W = 8;    // bus data width
    localparam int GPO_W  = 2;    // general-purpose output bits
endpackage

// File: rtl/isa_addr_decode.sv
// Address decoder: combines the address compare with chip enable and
// address enable. Assumes addr is steady while aen_n is low.
module isa_addr_decode
    import isa_io_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DEC_W-1:OFF_W] base_hi,
    input  logic              aen_n,
    input  logic              chip_en,
    output logic              hit,
    output logic [OFF_W-1:0]  offset
);
    // Chip enable low forces the effective address enable high.
    logic aen_eff_n;
    logic upper_zero;
    logic base_match;

    // Purpose: qualify the address compare.
    always_comb begin
        aen_eff_n  = aen_n | ~chip_en;
        upper_zero = (addr[ADDR_W-1:DEC_W] == '0);
        base_match = (addr[DEC_W-1:OFF_W] == base_hi);
        hit        = ~aen_eff_n & upper_zero & base_match;
        offset     = addr[OFF_W-1:0];
    end
endmodule

// File: rtl/isa_strobe_sync.sv
// Two-flop synchroniser for an active-low bus strobe with edge detection.
// Assumes the strobe is low for at least two clock periods.
module isa_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic low_sync,
    output logic fall,
    output logic rise
);
    logic s1, s2, s3;

    // Purpose: resynchronise the strobe and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= strobe_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Purpose: derive the level and edge indications.
    always_comb begin
        low_sync = ~s2;
        fall     = ~s2 & s3;
        rise     = s2 & ~s3;
    end

    assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    assert_single_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/isa_pin_router.sv
// Routes one request onto a selected pin of a pad group. Other pins
// stay undriven. With HOLD_PD set, an idle selected pin is left undriven
// with its weak pull-down enabled, so a device sharing the line can drive it.
module isa_pin_router #(
    parameter int N       = 5,
    parameter int SEL_W   = 3,
    parameter bit HOLD_PD = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic [SEL_W-1:0] sel,
    input  logic             req,
    output logic [N-1:0]     pin_o,
    output logic [N-1:0]     pin_oe,
    output logic [N-1:0]     pin_pd
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic chosen;
        assign chosen = chip_en && (sel == SEL_W'(i));
        if (HOLD_PD) begin : g_pd
            // Purpose: drive only an active request, else enable the pull-down.
            always_comb begin
                pin_oe[i] = chosen & req;
                pin_o[i]  = chosen & req;
                pin_pd[i] = chosen & ~req;
            end
        end else begin : g_drv
            // Purpose: drive the selected pin with the request level.
            always_comb begin
                pin_oe[i] = chosen;
                pin_o[i]  = chosen & req;
                pin_pd[i] = 1'b0;
            end
        end
    end

    assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_oe));
    assert_keeper_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & pin_pd) == '0) && $onehot0(pin_pd));
endmodule

// File: rtl/isa_io_front.sv
// ISA slave I/O front end: address decode, strobe synchronisation,
// transceiver enable, general-purpose output register, and routing of
// interrupt and DMA requests. Assumes bus address and data are steady
// while a strobe is low, and each strobe is low for three or more cycles.
module isa_io_front
    import isa_io_pkg::*;
#(
    parameter int OFF_W   = 4,
    parameter int N_IRQ   = 5,
    parameter int N_DRQ   = 3,
    parameter int GPO_OFF = 7,
    localparam int IRQ_SW = $clog2(N_IRQ + 1),
    localparam int DRQ_SW = $clog2(N_DRQ + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_rst,
    output logic                   bus_rst_n_o,
    input  logic                   chip_en,
    input  logic                   aen_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   ior_n,
    input  logic                   iow_n,
    input  logic [DEC_W-1:OFF_W]   base_hi,
    input  logic [DATA_W-1:0]      data_i,
    output logic [DATA_W-1:0]      data_o,
    output logic                   data_oe,
    output logic                   xcvr_en_n,
    output logic                   wr_stb,
    output logic [OFF_W-1:0]       wr_off,
    output logic [DATA_W-1:0]      wr_data,
    output logic                   rd_stb,
    output logic [OFF_W-1:0]       rd_off,
    input  logic [DATA_W-1:0]      rd_data,
    output logic [GPO_W-1:0]       gpo,
    input  logic [IRQ_SW-1:0]      irq_sel,
    input  logic                   irq_req,
    output logic [N_IRQ-1:0]       irq_o,
    output logic [N_IRQ-1:0]       irq_oe,
    input  logic [DRQ_SW-1:0]      drq_sel,
    input  logic                   drq_req,
    output logic [N_DRQ-1:0]       drq_o,
    output logic [N_DRQ-1:0]       drq_oe,
    output logic [N_DRQ-1:0]       drq_pd
);
    logic             hit;
    logic [OFF_W-1:0] offset;
    logic             wr_low, wr_fall, wr_rise;
    logic             rd_low, rd_fall, rd_rise;
    logic             cap_hit;
    logic [OFF_W-1:0] cap_off;
    logic [DATA_W-1:0] cap_data;

    isa_addr_decode #(.OFF_W(OFF_W)) u_dec (
        .addr(addr), .base_hi(base_hi), .aen_n(aen_n), .chip_en(chip_en),
        .hit(hit), .offset(offset)
    );

    isa_strobe_sync u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(iow_n),
        .low_sync(wr_low), .fall(wr_fall), .rise(wr_rise)
    );

    isa_strobe_sync u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(ior_n),
        .low_sync(rd_low), .fall(rd_fall), .rise(rd_rise)
    );

    // Purpose: sample decode, offset and data while the write strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hit  <= 1'b0;
            cap_off  <= '0;
            cap_data <= '0;
        end else if (wr_low) begin
            cap_hit  <= hit;
            cap_off  <= offset;
            cap_data <= data_i;
        end
    end

    // Purpose: general-purpose output register with asymmetric reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpo <= GPO_W'(2'b10);
        end else if (wr_stb && wr_off == OFF_W'(GPO_OFF)) begin
            gpo <= wr_data[GPO_W-1:0];
        end
    end

    // Purpose: internal strobes, read mux, bus and transceiver enables.
    always_comb begin
        wr_stb      = wr_rise & cap_hit;
        wr_off      = cap_off;
        wr_data     = cap_data;
        rd_stb      = rd_fall & hit;
        rd_off      = offset;
        data_oe     = hit & ~ior_n;
        xcvr_en_n   = ~(hit & (~ior_n | ~iow_n));
        bus_rst_n_o = ~bus_rst;
        if (offset == OFF_W'(GPO_OFF)) begin
            data_o = {{(DATA_W-GPO_W){1'b0}}, gpo};
        end else begin
            data_o = rd_data;
        end
    end

    isa_pin_router #(.N(N_IRQ), .SEL_W(IRQ_SW), .HOLD_PD(1'b0)) u_irq (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sel(irq_sel), .req(irq_req),
        .pin_o(irq_o), .pin_oe(irq_oe), .pin_pd()
    );

    isa_pin_router #(.N(N_DRQ), .SEL_W(DRQ_SW), .HOLD_PD(1'b1)) u_drq (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sel(drq_sel), .req(drq_req),
        .pin_o(drq_o), .pin_oe(drq_oe), .pin_pd(drq_pd)
    );

    assert_gpo_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_off == OFF_W'(GPO_OFF)) |=> gpo == $past(wr_data[GPO_W-1:0]));
    assert_gpo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_off == OFF_W'(GPO_OFF)) |=> $stable(gpo));
    assert_oe_needs_xcvr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !xcvr_en_n);
    assert_ce_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (irq_oe == '0 && drq_oe == '0 && drq_pd == '0 && !data_oe && !rd_stb));
    assert_no_wr_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(wr_low));
    assert_rd_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise |-> !rd_stb);
endmodule

// File: tb/isa_io_front_bench.sv
// Scoreboard bench: bus tasks queue the expected internal writes and a
// monitor pops and compares them at each write strobe.
module isa_io_front_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0;
    logic bus_rst_n_o;
    logic chip_en = 1'b1;
    logic aen_n = 1'b1;
    logic [11:0] addr = '0;
    logic ior_n = 1'b1;
    logic iow_n = 1'b1;
    logic [9:4] base_hi = 6'h22;
    logic [7:0] data_i = '0;
    logic [7:0] data_o;
    logic data_oe, xcvr_en_n, wr_stb, rd_stb;
    logic [3:0] wr_off, rd_off;
    logic [7:0] wr_data;
    logic [7:0] rd_data = 8'hA5;
    logic [1:0] gpo;
    logic [2:0] irq_sel = 3'd7;
    logic irq_req = 1'b0;
    logic [4:0] irq_o, irq_oe;
    logic [1:0] drq_sel = 2'd3;
    logic drq_req = 1'b0;
    logic [2:0] drq_o, drq_oe, drq_pd;

    int n_vec = 0;
    int n_bad = 0;
    logic [11:0] exp_q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_io_front u_isa_io_front (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_rst_n_o(bus_rst_n_o),
        .chip_en(chip_en), .aen_n(aen_n), .addr(addr), .ior_n(ior_n), .iow_n(iow_n),
        .base_hi(base_hi), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
        .xcvr_en_n(xcvr_en_n), .wr_stb(wr_stb), .wr_off(wr_off), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_off(rd_off), .rd_data(rd_data), .gpo(gpo),
        .irq_sel(irq_sel), .irq_req(irq_req), .irq_o(irq_o), .irq_oe(irq_oe),
        .drq_sel(drq_sel), .drq_req(drq_req), .drq_o(drq_o), .drq_oe(drq_oe),
        .drq_pd(drq_pd)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each internal write strobe (R5).
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected write", {4'h0, wr_off, wr_data}, 16'hFFFF);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check("R5 write offset/data", {4'h0, wr_off, wr_data}, {4'h0, e});
            end
        end
    end

    // Bus write cycle; exp_hit says whether the block should accept it.
    task automatic bus_write(input logic [11:0] a, input logic [7:0] d,
                             input logic aen_v, input bit exp_hit, input string tag);
        @(negedge clk);
        addr = a; data_i = d; aen_n = aen_v;
        @(negedge clk);
        iow_n = 1'b0;
        if (exp_hit) exp_q.push_back({a[3:0], d});
        repeat (2) @(negedge clk);
        check({tag, " R4 xcvr during write"}, {15'h0, xcvr_en_n}, {15'h0, !exp_hit});
        repeat (2) @(negedge clk);
        iow_n = 1'b1;
        repeat (5) @(negedge clk);
        aen_n = 1'b1;
    endtask

    // Bus read cycle: checks enable, data and a single read strobe.
    task automatic bus_read(input logic [11:0] a, input logic [7:0] exp_d, input string tag);
        int pulses;
        pulses = 0;
        @(negedge clk);
        addr = a; aen_n = 1'b0;
        @(negedge clk);
        ior_n = 1'b0;
        #1;
        check({tag, " R6 data_oe"}, {15'h0, data_oe}, 16'h1);
        check({tag, " R7 read data"}, {8'h0, data_o}, {8'h0, exp_d});
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (rd_stb) pulses++;
        end
        ior_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (rd_stb) pulses++;
        end
        check({tag, " R6 one rd_stb"}, 16'(pulses), 16'd1);
        check({tag, " R6 oe off after read"}, {15'h0, data_oe}, 16'h0);
        aen_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset gpo", {14'h0, gpo}, 16'h2);
        check("R4 reset xcvr", {15'h0, xcvr_en_n}, 16'h1);
        check("R6 reset oe", {15'h0, data_oe}, 16'h0);
        check("R9 bus reset low", {15'h0, bus_rst_n_o}, 16'h1);
        bus_rst = 1'b1; #1;
        check("R9 bus reset high", {15'h0, bus_rst_n_o}, 16'h0);
        bus_rst = 1'b0;

        bus_write(12'h227, 8'h01, 1'b0, 1'b1, "gpo write");
        check("R8 gpo after write", {14'h0, gpo}, 16'h1);
        bus_read(12'h227, 8'h01, "gpo read");
        bus_read(12'h223, 8'hA5, "reg read");

        bus_write(12'h222, 8'h5C, 1'b0, 1'b1, "plain write");
        check("R8 gpo untouched by offset 2", {14'h0, gpo}, 16'h1);

        bus_write(12'h627, 8'h02, 1'b0, 1'b0, "bit10 set");
        check("R1 bit10 write ignored", {14'h0, gpo}, 16'h1);
        bus_write(12'hA27, 8'h02, 1'b0, 1'b0, "bit11 set");
        check("R1 bit11 write ignored", {14'h0, gpo}, 16'h1);
        bus_write(12'h237, 8'h02, 1'b0, 1'b0, "base miss");
        check("R1 base mismatch ignored", {14'h0, gpo}, 16'h1);
        bus_write(12'h227, 8'h02, 1'b1, 1'b0, "aen high");
        check("R2 aen high ignored", {14'h0, gpo}, 16'h1);

        chip_en = 1'b0; irq_sel = 3'd1; irq_req = 1'b1; drq_sel = 2'd0; drq_req = 1'b0;
        bus_write(12'h227, 8'h02, 1'b0, 1'b0, "ce low");
        check("R3 ce low write ignored", {14'h0, gpo}, 16'h1);
        aen_n = 1'b0; addr = 12'h227; ior_n = 1'b0; #1;
        check("R3 ce low no oe", {15'h0, data_oe}, 16'h0);
        check("R3 ce low pads", {7'h0, irq_oe, drq_oe, drq_pd}, 16'h0);
        @(negedge clk); ior_n = 1'b1; aen_n = 1'b1;
        repeat (4) @(negedge clk);
        chip_en = 1'b1;

        irq_sel = 3'd2; irq_req = 1'b1; #1;
        check("R10 irq sel 2 oe", {11'h0, irq_oe}, 16'h04);
        check("R10 irq sel 2 high", {11'h0, irq_o}, 16'h04);
        irq_req = 1'b0; #1;
        check("R10 irq sel 2 low", {11'h0, irq_oe, 5'h0} | {11'h0, irq_o}, 16'h80);
        irq_sel = 3'd6; irq_req = 1'b1; #1;
        check("R10 irq none", {11'h0, irq_oe}, 16'h0);

        drq_sel = 2'd1; drq_req = 1'b0; #1;
        check("R11 drq idle", {7'h0, drq_oe, drq_pd, drq_o}, {7'h0, 3'b000, 3'b010, 3'b000});
        drq_req = 1'b1; #1;
        check("R11 drq active", {7'h0, drq_oe, drq_pd, drq_o}, {7'h0, 3'b010, 3'b000, 3'b010});
        drq_sel = 2'd3; #1;
        check("R11 drq none", {7'h0, drq_oe, drq_pd, drq_o}, 16'h0);

        bus_write(12'h227, 8'hFE, 1'b0, 1'b1, "gpo write 2");
        check("R8 gpo second write", {14'h0, gpo}, 16'h2);
        bus_read(12'h227, 8'h02, "gpo read 2");

        repeat (3) @(negedge clk);
        check("R5 queue drained", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule